// File: doc/BRIEF.md
# Counter-Timer Access Trap Decision Unit

This block decides, in a single combinational pass, whether a guest access to one of the counter or timer registers must be redirected to the hypervisor level. The inputs are the privilege level of the access (0 or 1) and the class of register it touches. The block also takes the hypervisor's mode bits: host mode, the routing bit that sends general traps to the hypervisor, and the three nested-virtualization bits. With these come a bit saying whether the hypervisor level is enabled, the hypervisor's timer-control enables and trap bits, and the kernel-level enables that govern level-0 accesses. The exception unit uses the answer before it commits the access.

Two trap outcomes are produced. The first is a kernel-level trap, which is taken at level 1. The second is a hypervisor trap. They never fire together, because a kernel-level trap always takes precedence over the hypervisor trap. When either one is raised, a 6-bit exception class marks the access as a trapped system-register access. When the hypervisor level is not enabled, every hypervisor mode bit is treated as 0.

Top module: `ctr_trap_unit`

## Requirements
- R1: When `hyp_on` is 0, `trap_hyp` is 0. The mode bits are then treated as 0, so the kernel-level rules of R8 apply as if `md_route` were 0.
- R2: Register classes are encoded as: physical counter 0, virtual counter 1, frequency 2, physical timer 3, virtual timer 4, nested physical timer 5, nested virtual timer 6. Code 7 is reserved. While `md_route` is 0, an access to class 0 at either level raises `trap_hyp` exactly when `g_pcnt_open` is 0, unless a kernel-level trap has already claimed it.
- R3: While `md_route` is 0, an access to class 3 at either level raises `trap_hyp` exactly when `g_ptmr_open` is 0, again unless a kernel-level trap has claimed it.
- R4: While `md_route` is 1, `g_pcnt_open`, `g_ptmr_open` and the kernel enables have no effect. A level-0 access to class 0, 1, 3 or 4 traps to the hypervisor when the matching enable among `u_pcnt_open`, `u_vcnt_open`, `u_ptmr_open` and `u_vtmr_open` is 0. A level-1 access to class 0 or 3 does not trap.
- R5: A frequency access (class 2) raises `trap_hyp` only at level 0, only while `md_route` is 1, and only when both `u_pcnt_open` and `u_vcnt_open` are 0.
- R6: `g_vcnt_trap` traps class 1 accesses and `g_vtmr_trap` traps class 4 accesses at either level. Both bits have no effect when `md_host` and `md_route` are both 1.
- R7: A level-1 access to class 5 traps when `n_ptmr_trap` is 1, and to class 6 when `n_vtmr_trap` is 1. Either trap requires all of the following: `md_host` and `md_route` not both 1, `md_nest`=1, `md_nest_lite`=0 and `md_nest_defer`=1. Level-0 accesses to these classes never trap.
- R8: `trap_kern` is raised only for level-0 accesses while the effective route bit is 0. It follows `k_pcnt_open` for class 0, `k_vcnt_open` for class 1, `k_ptmr_open` for class 3 and `k_vtmr_open` for class 4. For class 2 it is raised when both `k_pcnt_open` and `k_vcnt_open` are 0. When `trap_kern` is 1, `trap_hyp` is 0.
- R9: `exc_class` is 0x18 when either trap is raised and 0 otherwise.
- R10: An access with the reserved class code 7 raises neither trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| priv_lvl | input | 1 | Privilege level of the access (0 or 1) |
| reg_cls | input | 3 | Register class code of the access |
| hyp_on | input | 1 | Hypervisor level enabled for the current security state |
| md_host | input | 1 | Host-mode bit |
| md_route | input | 1 | Route-general-traps-to-hypervisor bit |
| md_nest | input | 1 | Nested-virtualization enable |
| md_nest_lite | input | 1 | Nested-virtualization alternate-mapping bit |
| md_nest_defer | input | 1 | Nested-virtualization deferred-access bit |
| g_pcnt_open | input | 1 | Guest physical-counter enable (1 = no trap) |
| g_ptmr_open | input | 1 | Guest physical-timer enable (1 = no trap) |
| g_vcnt_trap | input | 1 | Virtual-counter trap bit |
| g_vtmr_trap | input | 1 | Virtual-timer trap bit |
| u_pcnt_open | input | 1 | Level-0 physical-counter enable under routing |
| u_vcnt_open | input | 1 | Level-0 virtual-counter enable under routing |
| u_ptmr_open | input | 1 | Level-0 physical-timer enable under routing |
| u_vtmr_open | input | 1 | Level-0 virtual-timer enable under routing |
| n_ptmr_trap | input | 1 | Nested physical-timer trap bit |
| n_vtmr_trap | input | 1 | Nested virtual-timer trap bit |
| k_pcnt_open | input | 1 | Kernel-level physical-counter enable for level 0 |
| k_vcnt_open | input | 1 | Kernel-level virtual-counter enable for level 0 |
| k_ptmr_open | input | 1 | Kernel-level physical-timer enable for level 0 |
| k_vtmr_open | input | 1 | Kernel-level virtual-timer enable for level 0 |
| trap_hyp | output | 1 | Access traps to the hypervisor level |
| trap_kern | output | 1 | Access traps to level 1 (kernel) |
| exc_class | output | 6 | Exception class of the trap, 0 when none |

## Verification
The assertions are evaluated every time the inputs change. They cover the safety properties: the hypervisor trap stays silent while the hypervisor level is off, the two traps are mutually exclusive, the reserved class code never traps, and the exception class agrees with both trap outputs. They also check that a frequency or nested trap only appears under its enabling mode combination, and that host mode with routing masks the virtual trap bits. The scenarios have to show the positive direction: that each enable actually produces its trap, and that a kernel enable hands a trap back from the hypervisor to level 1. The scenarios also show that bits ignored under routing leave the outputs unchanged.

// File: rtl/ctrap_pkg.sv
package ctrap_pkg;

  typedef enum logic [2:0] {
    RC_PCNT  = 3'd0,
    RC_VCNT  = 3'd1,
    RC_FREQ  = 3'd2,
    RC_PTMR  = 3'd3,
    RC_VTMR  = 3'd4,
    RC_NPTMR = 3'd5,
    RC_NVTMR = 3'd6,
    RC_RSVD  = 3'd7
  } reg_cls_e;

  typedef struct packed {
    logic host;
    logic route;
    logic nest;
    logic nest_lite;
    logic nest_defer;
  } hmode_t;

  // virtual trap bits are masked when host mode and routing are both set
  function automatic logic vbits_live(hmode_t m);
    return !(m.host && m.route);
  endfunction

  // only one combination of the nested bits arms the nested timer traps
  function automatic logic nest_armed(hmode_t m);
    return vbits_live(m) && m.nest && !m.nest_lite && m.nest_defer;
  endfunction

endpackage

// File: rtl/ctrap_kern_dec.sv
module ctrap_kern_dec
  import ctrap_pkg::*;
(
  input  logic       priv_lvl,
  input  logic       route_eff,
  input  logic [2:0] cls,
  input  logic       k_pcnt_open,
  input  logic       k_vcnt_open,
  input  logic       k_ptmr_open,
  input  logic       k_vtmr_open,
  output logic       kern_hit
);

  logic active;
  assign active = !priv_lvl && !route_eff;

  always_comb begin
    kern_hit = 1'b0;
    if (active) begin
      case (reg_cls_e'(cls))
        RC_PCNT: kern_hit = !k_pcnt_open;
        RC_VCNT: kern_hit = !k_vcnt_open;
        RC_FREQ: kern_hit = !k_pcnt_open && !k_vcnt_open;
        RC_PTMR: kern_hit = !k_ptmr_open;
        RC_VTMR: kern_hit = !k_vtmr_open;
        default: kern_hit = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/ctrap_hyp_dec.sv
module ctrap_hyp_dec
  import ctrap_pkg::*;
(
  input  logic       priv_lvl,
  input  logic [2:0] cls,
  input  hmode_t     mode,
  input  logic       g_pcnt_open,
  input  logic       g_ptmr_open,
  input  logic       g_vcnt_trap,
  input  logic       g_vtmr_trap,
  input  logic       u_pcnt_open,
  input  logic       u_vcnt_open,
  input  logic       u_ptmr_open,
  input  logic       u_vtmr_open,
  output logic       hyp_hit
);

  logic lvl0_routed;
  logic vlive;
  assign lvl0_routed = mode.route && !priv_lvl;
  assign vlive       = vbits_live(mode);

  always_comb begin
    case (reg_cls_e'(cls))
      RC_PCNT: hyp_hit = mode.route ? (lvl0_routed && !u_pcnt_open) : !g_pcnt_open;
      RC_PTMR: hyp_hit = mode.route ? (lvl0_routed && !u_ptmr_open) : !g_ptmr_open;
      RC_VCNT: hyp_hit = (vlive && g_vcnt_trap) || (lvl0_routed && !u_vcnt_open);
      RC_VTMR: hyp_hit = (vlive && g_vtmr_trap) || (lvl0_routed && !u_vtmr_open);
      RC_FREQ: hyp_hit = lvl0_routed && !u_pcnt_open && !u_vcnt_open;
      default: hyp_hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/ctrap_nest_dec.sv
module ctrap_nest_dec
  import ctrap_pkg::*;
#(
  parameter reg_cls_e NEST_CLS = RC_NPTMR
) (
  input  logic       priv_lvl,
  input  logic [2:0] cls,
  input  hmode_t     mode,
  input  logic       trap_bit,
  output logic       nest_hit
);

  assign nest_hit = priv_lvl && (reg_cls_e'(cls) == NEST_CLS) && trap_bit && nest_armed(mode);

endmodule

// File: rtl/ctr_trap_unit.sv
module ctr_trap_unit
  import ctrap_pkg::*;
#(
  parameter int              EC_WIDTH  = 6,
  parameter logic [EC_WIDTH-1:0] EC_SYSREG = 6'h18
) (
  input  logic                priv_lvl,
  input  logic [2:0]          reg_cls,
  input  logic                hyp_on,
  input  logic                md_host,
  input  logic                md_route,
  input  logic                md_nest,
  input  logic                md_nest_lite,
  input  logic                md_nest_defer,
  input  logic                g_pcnt_open,
  input  logic                g_ptmr_open,
  input  logic                g_vcnt_trap,
  input  logic                g_vtmr_trap,
  input  logic                u_pcnt_open,
  input  logic                u_vcnt_open,
  input  logic                u_ptmr_open,
  input  logic                u_vtmr_open,
  input  logic                n_ptmr_trap,
  input  logic                n_vtmr_trap,
  input  logic                k_pcnt_open,
  input  logic                k_vcnt_open,
  input  logic                k_ptmr_open,
  input  logic                k_vtmr_open,
  output logic                trap_hyp,
  output logic                trap_kern,
  output logic [EC_WIDTH-1:0] exc_class
);

  localparam int NEST_CNT = 2;

  hmode_t mode_raw;
  hmode_t mode_eff;
  logic   kern_hit;
  logic   hyp_hit;
  logic [NEST_CNT-1:0] nest_hit;
  logic [NEST_CNT-1:0] nest_bits;

  assign mode_raw  = '{host: md_host, route: md_route, nest: md_nest,
                       nest_lite: md_nest_lite, nest_defer: md_nest_defer};
  // a disabled hypervisor level behaves as if all its mode bits were clear
  assign mode_eff  = hyp_on ? mode_raw : '0;
  assign nest_bits = {n_vtmr_trap, n_ptmr_trap};

  ctrap_kern_dec u_kern (
    .priv_lvl    (priv_lvl),
    .route_eff   (mode_eff.route),
    .cls         (reg_cls),
    .k_pcnt_open (k_pcnt_open),
    .k_vcnt_open (k_vcnt_open),
    .k_ptmr_open (k_ptmr_open),
    .k_vtmr_open (k_vtmr_open),
    .kern_hit    (kern_hit)
  );

  ctrap_hyp_dec u_hyp (
    .priv_lvl    (priv_lvl),
    .cls         (reg_cls),
    .mode        (mode_eff),
    .g_pcnt_open (g_pcnt_open),
    .g_ptmr_open (g_ptmr_open),
    .g_vcnt_trap (g_vcnt_trap),
    .g_vtmr_trap (g_vtmr_trap),
    .u_pcnt_open (u_pcnt_open),
    .u_vcnt_open (u_vcnt_open),
    .u_ptmr_open (u_ptmr_open),
    .u_vtmr_open (u_vtmr_open),
    .hyp_hit     (hyp_hit)
  );

  for (genvar gi = 0; gi < NEST_CNT; gi++) begin : g_nest
    localparam reg_cls_e CLS_I = (gi == 0) ? RC_NPTMR : RC_NVTMR;
    ctrap_nest_dec #(.NEST_CLS(CLS_I)) u_nest (
      .priv_lvl (priv_lvl),
      .cls      (reg_cls),
      .mode     (mode_eff),
      .trap_bit (nest_bits[gi]),
      .nest_hit (nest_hit[gi])
    );
  end

  // kernel-level trap wins; hypervisor trap needs the level enabled
  assign trap_kern = kern_hit;
  assign trap_hyp  = hyp_on && !kern_hit && (hyp_hit || (|nest_hit));
  assign exc_class = (trap_hyp || trap_kern) ? EC_SYSREG : '0;

endmodule

// File: rtl/ctrap_chk.sv
module ctrap_chk (
  input logic       priv_lvl,
  input logic [2:0] reg_cls,
  input logic       hyp_on,
  input logic       md_host,
  input logic       md_route,
  input logic       md_nest,
  input logic       md_nest_lite,
  input logic       md_nest_defer,
  input logic       u_pcnt_open,
  input logic       u_vcnt_open,
  input logic       trap_hyp,
  input logic       trap_kern,
  input logic [5:0] exc_class
);

  always_comb begin
    // R1
    hyp_off_quiet_chk: assert (hyp_on || !trap_hyp);
    // R8
    one_target_chk: assert (!(trap_hyp && trap_kern));
    // R10
    rsvd_cls_chk: assert (reg_cls != 3'd7 || (!trap_hyp && !trap_kern));
    // R9
    ec_on_trap_chk: assert (!(trap_hyp || trap_kern) || exc_class == 6'h18);
    // R9
    ec_idle_chk: assert ((trap_hyp || trap_kern) || exc_class == 6'h00);
    // R5
    freq_gate_chk: assert (!(trap_hyp && reg_cls == 3'd2) ||
                           (md_route && !priv_lvl && !u_pcnt_open && !u_vcnt_open));
    // R7
    nest_gate_chk: assert (!(trap_hyp && (reg_cls == 3'd5 || reg_cls == 3'd6)) ||
                           (priv_lvl && md_nest && !md_nest_lite && md_nest_defer &&
                            !(md_host && md_route)));
    // R6
    vmask_chk: assert (!(hyp_on && md_host && md_route && priv_lvl &&
                         (reg_cls == 3'd1 || reg_cls == 3'd4)) || !trap_hyp);
  end

endmodule

bind ctr_trap_unit ctrap_chk u_chk (
  .priv_lvl      (priv_lvl),
  .reg_cls       (reg_cls),
  .hyp_on        (hyp_on),
  .md_host       (md_host),
  .md_route      (md_route),
  .md_nest       (md_nest),
  .md_nest_lite  (md_nest_lite),
  .md_nest_defer (md_nest_defer),
  .u_pcnt_open   (u_pcnt_open),
  .u_vcnt_open   (u_vcnt_open),
  .trap_hyp      (trap_hyp),
  .trap_kern     (trap_kern),
  .exc_class     (exc_class)
);

// File: tb/sim_ctr_trap_unit.sv
module sim_ctr_trap_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 24;

  // {req[3:0], priv, cls[2:0], hyp_on, mode{host,route,nest,lite,defer},
  //  g{pcnt_open,ptmr_open,vcnt_trap,vtmr_trap}, u{pcnt,vcnt,ptmr,vtmr},
  //  n{ptmr,vtmr}, k{pcnt,vcnt,ptmr,vtmr}, exp{hyp,kern}}
  localparam logic [29:0] VEC [NVEC] = '{
    {4'd2,  1'b1,3'd0,1'b1,5'b00000,4'b0100,4'b1111,2'b00,4'b1111,2'b10}, // R2 trap
    {4'd2,  1'b1,3'd0,1'b1,5'b00000,4'b1100,4'b1111,2'b00,4'b1111,2'b00}, // R2 open
    {4'd8,  1'b0,3'd0,1'b1,5'b00000,4'b0100,4'b1111,2'b00,4'b0111,2'b01}, // R8 kernel wins
    {4'd2,  1'b0,3'd0,1'b1,5'b00000,4'b0100,4'b1111,2'b00,4'b1111,2'b10}, // R2 lvl0
    {4'd3,  1'b1,3'd3,1'b1,5'b00000,4'b1000,4'b1111,2'b00,4'b1111,2'b10}, // R3
    {4'd8,  1'b0,3'd3,1'b1,5'b00000,4'b1000,4'b1111,2'b00,4'b1101,2'b01}, // R8 timer
    {4'd4,  1'b0,3'd3,1'b1,5'b01000,4'b0000,4'b1101,2'b00,4'b0000,2'b10}, // R4 ptmr
    {4'd4,  1'b1,3'd0,1'b1,5'b01000,4'b0000,4'b1111,2'b00,4'b0000,2'b00}, // R4 g ignored
    {4'd4,  1'b0,3'd4,1'b1,5'b01000,4'b1100,4'b1110,2'b00,4'b1111,2'b10}, // R4 vtmr
    {4'd5,  1'b0,3'd2,1'b1,5'b01000,4'b1100,4'b0011,2'b00,4'b1111,2'b10}, // R5 trap
    {4'd5,  1'b0,3'd2,1'b1,5'b01000,4'b1100,4'b0111,2'b00,4'b1111,2'b00}, // R5 one open
    {4'd5,  1'b0,3'd2,1'b1,5'b00000,4'b1100,4'b0000,2'b00,4'b1111,2'b00}, // R5 no route
    {4'd8,  1'b0,3'd2,1'b1,5'b00000,4'b1100,4'b1111,2'b00,4'b0011,2'b01}, // R8 freq
    {4'd6,  1'b1,3'd1,1'b1,5'b00000,4'b1110,4'b1111,2'b00,4'b1111,2'b10}, // R6 vcnt
    {4'd6,  1'b1,3'd1,1'b1,5'b11000,4'b1110,4'b1111,2'b00,4'b1111,2'b00}, // R6 masked
    {4'd6,  1'b1,3'd4,1'b1,5'b10000,4'b1101,4'b1111,2'b00,4'b1111,2'b10}, // R6 host only
    {4'd7,  1'b1,3'd5,1'b1,5'b00101,4'b1100,4'b1111,2'b10,4'b1111,2'b10}, // R7 armed
    {4'd7,  1'b1,3'd5,1'b1,5'b00111,4'b1100,4'b1111,2'b10,4'b1111,2'b00}, // R7 lite set
    {4'd7,  1'b1,3'd5,1'b1,5'b11101,4'b1100,4'b1111,2'b10,4'b1111,2'b00}, // R7 host+route
    {4'd7,  1'b1,3'd6,1'b1,5'b10101,4'b1100,4'b1111,2'b01,4'b1111,2'b10}, // R7 virt
    {4'd7,  1'b0,3'd6,1'b1,5'b00101,4'b1100,4'b1111,2'b01,4'b1111,2'b00}, // R7 lvl0
    {4'd1,  1'b1,3'd0,1'b0,5'b00000,4'b0000,4'b1111,2'b00,4'b1111,2'b00}, // R1 hyp off
    {4'd1,  1'b0,3'd0,1'b0,5'b01000,4'b0000,4'b1111,2'b00,4'b0111,2'b01}, // R1 route masked
    {4'd10, 1'b0,3'd7,1'b1,5'b00000,4'b0000,4'b0000,2'b11,4'b0000,2'b00}  // R10
  };

  logic clk = 1'b0;
  logic priv_lvl, hyp_on;
  logic [2:0] reg_cls;
  logic [4:0] mode;
  logic [3:0] gb, ub, kb;
  logic [1:0] nb;
  logic trap_hyp, trap_kern;
  logic [5:0] exc_class;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctr_trap_unit u0 (
    .priv_lvl(priv_lvl), .reg_cls(reg_cls), .hyp_on(hyp_on),
    .md_host(mode[4]), .md_route(mode[3]), .md_nest(mode[2]),
    .md_nest_lite(mode[1]), .md_nest_defer(mode[0]),
    .g_pcnt_open(gb[3]), .g_ptmr_open(gb[2]), .g_vcnt_trap(gb[1]), .g_vtmr_trap(gb[0]),
    .u_pcnt_open(ub[3]), .u_vcnt_open(ub[2]), .u_ptmr_open(ub[1]), .u_vtmr_open(ub[0]),
    .n_ptmr_trap(nb[1]), .n_vtmr_trap(nb[0]),
    .k_pcnt_open(kb[3]), .k_vcnt_open(kb[2]), .k_ptmr_open(kb[1]), .k_vtmr_open(kb[0]),
    .trap_hyp(trap_hyp), .trap_kern(trap_kern), .exc_class(exc_class)
  );

  task automatic check(input int req, input logic eh, input logic ek);
    logic [5:0] eec;
    eec = (eh || ek) ? 6'h18 : 6'h00;
    total++;
    if (trap_hyp !== eh || trap_kern !== ek) begin
      bad++;
      $display("FAIL R%0d traps hyp/kern actual=%b%b expected=%b%b", req, trap_hyp, trap_kern, eh, ek);
    end
    total++;
    if (exc_class !== eec) begin
      bad++;
      $display("FAIL R9 (with R%0d) exc_class actual=%h expected=%h", req, exc_class, eec);
    end
  endtask

  task automatic apply(input logic [29:0] v);
    @(posedge clk);
    {priv_lvl, reg_cls, hyp_on, mode, gb, ub, nb, kb} = v[25:2];
    @(negedge clk);
    check(int'(v[29:26]), v[1], v[0]);
  endtask

  initial begin
    // idle state: hypervisor off, every enable open
    priv_lvl = 1'b0; reg_cls = 3'd0; hyp_on = 1'b0; mode = 5'b0;
    gb = 4'b1100; ub = 4'b1111; nb = 2'b00; kb = 4'b1111;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(1, 1'b0, 1'b0); // R1 idle state
    for (int i = 0; i < NVEC; i++) apply(VEC[i]);
    // R10 reserved code across levels and routing, all traps asked for
    for (int p = 0; p < 2; p++) begin
      for (int r = 0; r < 2; r++) begin
        apply({4'd10, p[0], 3'd7, 1'b1, 1'b0, r[0], 3'b101, 4'b0011, 4'b0000, 2'b11, 4'b0000, 2'b00});
      end
    end
    // R8 kernel trap hands back the vcnt hypervisor trap
    apply({4'd8, 1'b0, 3'd1, 1'b1, 5'b00000, 4'b1110, 4'b1111, 2'b00, 4'b1011, 2'b01});
    // R4 kernel enable ignored under routing, level-0 vcnt open
    apply({4'd4, 1'b0, 3'd1, 1'b1, 5'b11000, 4'b1100, 4'b1111, 2'b00, 4'b0000, 2'b00});
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule